// File: doc/BRIEF.md
# Dual-Mode 8-Bit Tick Timer with Divided Clock Output

The block is an 8-bit up-counter that produces periodic overflow events for a processor. In interval mode it advances on one of eight tap pulses taken from a free-running prescaler on the system clock. In time-base mode it advances on tap pulses from a second prescaler. That prescaler runs on a slow sub-clock, nominally 32.768 kHz. Its taps are brought into the system domain through a synchronizer and an edge detector. Each overflow raises a sticky flag, which software clears by writing 0 to it. An interrupt request follows the flag whenever the enable is set.

A separate path drives a clock pin with one of eight square waves. The system clock or the sub-clock is divided by 4, 8, 16 or 32 to make them. Software reaches the block through a small register port: a mode register, a read-only view of the counter, and a control register. The control register holds the flag, the interrupt enable and the clock-output enable. No data streams cross the block edge, so every pin is a plain control or status signal.

Top module: `tick_timer8`

## Requirements
- R1: After reset the mode register reads 0x00, the counter reads 0x00, the control register reads 0x00, and both `irq` and `clk_out` are low. The counter begins counting at once in interval mode with select code 0.
- R2: When mode bit 3 is 0, mode bits [2:0] choose the interval count rate. Codes 0 to 7 advance the counter once every 8192, 4096, 2048, 512, 256, 128, 32 and 8 system clocks, exactly.
- R3: A count step taken while the counter holds 0xFF returns it to 0x00 and sets the overflow flag (control bit 0) on the same edge. Counting then continues.
- R4: `irq` is high exactly while the flag and the interrupt enable (control bit 1) are both 1. It stays high as a level until one of them is cleared.
- R5: Writing the control register with bit 0 at 0 clears the flag. Writing bit 0 at 1 leaves the flag unchanged.
- R6: If a flag-clearing write and an overflow fall on the same clock edge, the flag ends up set.
- R7: When mode bit 3 is 1, mode bits [1:0] choose a sub-clock divisor. Codes 0 to 3 select 128, 64, 32 and 8 sub-clock periods per count step. Each step is timed to within one system clock.
- R8: A write to the mode register with bits 3 and 2 both at 1 clears the counter on that edge. It also restarts the sub-clock prescaler from zero, so the first following count step comes no sooner than one full selected period after the write.
- R9: With control bit 2 at 1, mode bits [7:5] select the signal on `clk_out`. Codes 0 to 3 give the system clock divided by 32, 16, 8 and 4. Codes 4 to 7 give the sub-clock divided by 32, 16, 8 and 4. With control bit 2 at 0, `clk_out` stays low.
- R10: Address 0 is the mode register and reads back as written. Address 1 returns the counter and ignores writes. Address 2 is the control register, laid out as {5'b0, clock-output enable, interrupt enable, flag}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset for both clock domains |
| sub_clk | input | 1 | Slow sub-clock for the time-base prescaler |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 2 | Register address: 0 mode, 1 counter, 2 control |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| irq | output | 1 | Overflow interrupt request, level |
| clk_out | output | 1 | Selected divided clock, registered in the system domain |

## Verification
The bench uses the default parameters: an 8-bit counter, a 13-bit system prescaler and a 7-bit sub-clock prescaler. With these, the slowest interval tap of 8192 clocks and a full 256-step overflow at the fastest tap both fit in a short run. The sub-clock is driven at 37 ns instead of its true rate, which keeps every time-base period and divided output within a few thousand system cycles. Because 37 ns is not a multiple of the 5 ns system clock, the edges are not aligned, and the one-clock synchronizer tolerance of R7 and R9 gets exercised. The two prescaler strides used in the collision test are exact and known from the ports, so a clear write can be placed on the very edge of an overflow.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

  typedef struct packed {
    logic [2:0] out_sel;
    logic       spare;
    logic       tb_mode;
    logic [2:0] sel;
  } mode_t;

  typedef enum logic [1:0] {
    ADR_MODE  = 2'd0,
    ADR_COUNT = 2'd1,
    ADR_CTRL  = 2'd2,
    ADR_NONE  = 2'd3
  } addr_e;

  // log2 of the system-prescaler divisor per interval select code
  function automatic int sys_tap_log2(input int code);
    case (code)
      0: return 13;
      1: return 12;
      2: return 11;
      3: return 9;
      4: return 8;
      5: return 7;
      6: return 5;
      default: return 3;
    endcase
  endfunction

  // log2 of the sub-prescaler divisor per time-base period code
  function automatic int sub_tap_log2(input int code);
    case (code)
      0: return 7;
      1: return 6;
      2: return 5;
      default: return 3;
    endcase
  endfunction

  // log2 of the divisor for each clock-output code (both sources share it)
  function automatic int out_tap_log2(input int code);
    case (code % 4)
      0: return 5;
      1: return 4;
      2: return 3;
      default: return 2;
    endcase
  endfunction

endpackage

// File: rtl/tmr8_sysdiv.sv
module tmr8_sysdiv
  import tmr8_pkg::*;
#(
  parameter int PRE_W = 13,
  parameter int NSEL  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [$clog2(NSEL)-1:0] sel,
  output logic                    tick,
  output logic [3:0]              out_taps
);
  logic [PRE_W-1:0] pre_q;
  logic [NSEL-1:0]  tap_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_q + 1'b1;
  end

  // a tap fires on the cycle its low bits are all ones (the wrap point)
  for (genvar i = 0; i < NSEL; i++) begin : g_tap
    localparam int K = sys_tap_log2(i);
    assign tap_v[i] = &pre_q[K-1:0];
  end

  assign tick     = tap_v[sel];
  assign out_taps = pre_q[4:1];

  assert_tick_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tap_v[sel] && $stable(sel) |=> !tap_v[sel]);

endmodule

// File: rtl/tmr8_subbase.sv
module tmr8_subbase
  import tmr8_pkg::*;
#(
  parameter int PRE_W = 7,
  parameter int NPER  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sub_clk,
  input  logic                    clr_pulse,
  input  logic [$clog2(NPER)-1:0] per_sel,
  output logic                    tb_tick,
  output logic                    busy,
  output logic [3:0]              out_taps
);
  logic             req_q, ack_s1, ack_s2;
  logic             rq_s1, rq_s2;
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:1] b_s1, b_s2;
  logic [NPER-1:0]  tap_d, fall_v;

  // clear request held in the system domain until the sub domain echoes it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         req_q <= 1'b0;
    else if (clr_pulse) req_q <= 1'b1;
    else if (ack_s2)    req_q <= 1'b0;
  end

  always_ff @(posedge sub_clk or negedge rst_n) begin
    if (!rst_n) {rq_s2, rq_s1} <= 2'b00;
    else        {rq_s2, rq_s1} <= {rq_s1, req_q};
  end

  always_ff @(posedge sub_clk or negedge rst_n) begin
    if (!rst_n)     pre_q <= '0;
    else if (rq_s2) pre_q <= '0;
    else            pre_q <= pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {ack_s2, ack_s1} <= 2'b00;
      b_s1 <= '0;
      b_s2 <= '0;
    end else begin
      {ack_s2, ack_s1} <= {ack_s1, rq_s2};
      b_s1 <= pre_q[PRE_W-1:1];
      b_s2 <= b_s1;
    end
  end

  assign busy = req_q | ack_s2;

  // a count step is the falling edge of the synchronized tap bit
  for (genvar p = 0; p < NPER; p++) begin : g_per
    localparam int K = sub_tap_log2(p);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tap_d[p] <= 1'b0;
      else        tap_d[p] <= b_s2[K-1];
    end
    assign fall_v[p] = tap_d[p] & ~b_s2[K-1];

    assert_tap_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fall_v[p] |=> !fall_v[p]);
  end

  assign tb_tick  = fall_v[per_sel];
  assign out_taps = b_s2[4:1];

  assert_clear_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |=> busy);

endmodule

// File: rtl/tmr8_clkout.sv
module tmr8_clkout
  import tmr8_pkg::*;
#(
  parameter int NSRC = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    oe,
  input  logic [$clog2(NSRC)-1:0] sel,
  input  logic [3:0]              sys_taps,
  input  logic [3:0]              sub_taps,
  output logic                    clk_out
);
  logic [NSRC-1:0] src_v;

  // tap index j carries divide-by-2^(j+2)
  for (genvar c = 0; c < NSRC; c++) begin : g_src
    localparam int J = out_tap_log2(c) - 2;
    if (c < NSRC / 2) begin : g_sys
      assign src_v[c] = sys_taps[J];
    end else begin : g_sub
      assign src_v[c] = sub_taps[J];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clk_out <= 1'b0;
    else        clk_out <= oe & src_v[sel];
  end

  assert_off_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |=> !clk_out);

endmodule

// File: rtl/tmr8_count.sv
module tmr8_count #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             cnt_clr,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cnt_q,
  output logic             flag_q
);
  logic wrap;

  assign wrap = cnt_en && !cnt_clr && (&cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (cnt_clr) cnt_q <= '0;
    else if (cnt_en)  cnt_q <= cnt_q + 1'b1;
  end

  // overflow has priority over a software clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (wrap)     flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end

  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !cnt_clr && cnt_q == '1) |=> (cnt_q == '0 && flag_q));

  assert_ovf_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && cnt_en && !cnt_clr && cnt_q == '1) |=> flag_q);

  assert_flag_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !(cnt_en && cnt_q == '1)) |=> !flag_q);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !cnt_clr) |=> $stable(cnt_q));

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> cnt_q == '0);

endmodule

// File: rtl/tick_timer8.sv
module tick_timer8
  import tmr8_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int SYS_PRE_W = 13,
  parameter int SUB_PRE_W = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sub_clk,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  output logic       clk_out
);
  mode_t            mode_q;
  logic             ie_q, oe_q;
  logic             wr_mode, wr_ctrl;
  logic             tb_clear, flag_clr;
  logic             sys_tick, tb_tick, tb_busy, cnt_en;
  logic [3:0]       sys_taps, sub_taps;
  logic [CNT_W-1:0] cnt;
  logic             flag;

  assign wr_mode  = reg_wr && (addr_e'(reg_addr) == ADR_MODE);
  assign wr_ctrl  = reg_wr && (addr_e'(reg_addr) == ADR_CTRL);
  assign tb_clear = wr_mode && reg_wdata[3] && reg_wdata[2];
  assign flag_clr = wr_ctrl && !reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      ie_q   <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      if (wr_mode) mode_q <= mode_t'(reg_wdata);
      if (wr_ctrl) begin
        ie_q <= reg_wdata[1];
        oe_q <= reg_wdata[2];
      end
    end
  end

  tmr8_sysdiv #(.PRE_W(SYS_PRE_W), .NSEL(8)) u_sysdiv (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (mode_q.sel),
    .tick     (sys_tick),
    .out_taps (sys_taps)
  );

  tmr8_subbase #(.PRE_W(SUB_PRE_W), .NPER(4)) u_subbase (
    .clk       (clk),
    .rst_n     (rst_n),
    .sub_clk   (sub_clk),
    .clr_pulse (tb_clear),
    .per_sel   (mode_q.sel[1:0]),
    .tb_tick   (tb_tick),
    .busy      (tb_busy),
    .out_taps  (sub_taps)
  );

  assign cnt_en = mode_q.tb_mode ? (tb_tick && !tb_busy) : sys_tick;

  tmr8_count #(.CNT_W(CNT_W)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_en   (cnt_en),
    .cnt_clr  (tb_clear),
    .flag_clr (flag_clr),
    .cnt_q    (cnt),
    .flag_q   (flag)
  );

  tmr8_clkout #(.NSRC(8)) u_clkout (
    .clk      (clk),
    .rst_n    (rst_n),
    .oe       (oe_q),
    .sel      (mode_q.out_sel),
    .sys_taps (sys_taps),
    .sub_taps (sub_taps),
    .clk_out  (clk_out)
  );

  assign irq = flag & ie_q;

  always_comb begin
    reg_rdata = '0;
    case (addr_e'(reg_addr))
      ADR_MODE:  reg_rdata = mode_q;
      ADR_COUNT: reg_rdata[CNT_W-1:0] = cnt;
      ADR_CTRL:  reg_rdata[2:0] = {oe_q, ie_q, flag};
      default:   reg_rdata = '0;
    endcase
  end

  assert_irq_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(wr_ctrl));

  assert_irq_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($rose(flag) || $past(wr_ctrl)));

endmodule

// File: tb/tick_timer8_tb.sv
`timescale 1ns/1ps
module tick_timer8_tb;
  localparam real CLK_P = 5.0;
  localparam real SUB_P = 37.0;
  localparam int  NVEC  = 20;
  localparam int  LIMIT = 20000;

  // {kind[1:0], code[2:0], log2 divisor[3:0]}; kind 0 interval, 1 time base, 2 clock out
  localparam logic [8:0] VEC [NVEC] = '{
    {2'd0, 3'd0, 4'd13}, {2'd0, 3'd1, 4'd12}, {2'd0, 3'd2, 4'd11}, {2'd0, 3'd3, 4'd9},
    {2'd0, 3'd4, 4'd8},  {2'd0, 3'd5, 4'd7},  {2'd0, 3'd6, 4'd5},  {2'd0, 3'd7, 4'd3},
    {2'd1, 3'd0, 4'd7},  {2'd1, 3'd1, 4'd6},  {2'd1, 3'd2, 4'd5},  {2'd1, 3'd3, 4'd3},
    {2'd2, 3'd0, 4'd5},  {2'd2, 3'd1, 4'd4},  {2'd2, 3'd2, 4'd3},  {2'd2, 3'd3, 4'd2},
    {2'd2, 3'd4, 4'd5},  {2'd2, 3'd5, 4'd4},  {2'd2, 3'd6, 4'd3},  {2'd2, 3'd7, 4'd2}
  };

  logic       clk = 1'b0, sub_clk = 1'b0, rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq, clk_out;

  int n_chk = 0, n_fail = 0;
  bit timed_out = 1'b0, done = 1'b0;

  always #2.5 clk = ~clk;
  always #18.5 sub_clk = ~sub_clk;

  tick_timer8 u_dut (
    .clk(clk), .rst_n(rst_n), .sub_clk(sub_clk), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .clk_out(clk_out)
  );

  task automatic check(input bit ok, input string tag, input string msg);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", tag, msg);
    end
  endtask

  task automatic summary();
    if (timed_out) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung run, expected completion");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_cnt_change(output realtime t);
    logic [7:0] v0, v;
    int n = 0;
    rd(2'd1, v0);
    do begin
      rd(2'd1, v);
      n++;
    end while (v == v0 && n < LIMIT);
    if (n >= LIMIT) timed_out = 1'b1;
    t = $realtime;
  endtask

  task automatic wait_out_rise(output realtime t);
    logic prev, cur;
    int n = 0;
    @(negedge clk); prev = clk_out;
    do begin
      @(negedge clk); cur = clk_out;
      n++;
      if (!(cur && !prev)) prev = cur;
    end while (!(cur && !prev) && n < LIMIT);
    if (n >= LIMIT) timed_out = 1'b1;
    t = $realtime;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      timed_out = 1'b1;
      summary();
    end
  end

  initial begin
    logic [7:0] v;
    realtime t0, t1;
    real d, expv, tol, base;
    logic [1:0] kind;
    logic [2:0] code;
    int sh;
    string tag;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rd(2'd0, v); check(v == 8'h00, "R1", $sformatf("mode actual %h expected 00", v));
    rd(2'd1, v); check(v == 8'h00, "R1", $sformatf("count actual %h expected 00", v));
    rd(2'd2, v); check(v == 8'h00, "R1", $sformatf("ctrl actual %h expected 00", v));
    check(irq == 1'b0, "R1", $sformatf("irq actual %b expected 0", irq));
    begin
      bit seen = 1'b0;
      for (int i = 0; i < 100; i++) begin
        @(negedge clk);
        if (clk_out) seen = 1'b1;
      end
      check(!seen, "R9", "clk_out actual toggling expected low while disabled");
    end

    // table of rate vectors: R2 interval, R7 time base, R9 clock output
    for (int i = 0; i < NVEC; i++) begin
      kind = VEC[i][8:7];
      code = VEC[i][6:4];
      sh   = int'(VEC[i][3:0]);
      if (kind == 2'd0) begin
        tag = "R2"; base = CLK_P; tol = 0.0;
        wr(2'd0, {5'b0, code});
        wait_cnt_change(t0); wait_cnt_change(t0); wait_cnt_change(t1);
      end else if (kind == 2'd1) begin
        tag = "R7"; base = SUB_P; tol = CLK_P;
        wr(2'd0, {4'b0, 1'b1, 1'b0, code[1:0]});
        wait_cnt_change(t0); wait_cnt_change(t0); wait_cnt_change(t1);
      end else begin
        tag = "R9"; base = (code < 3'd4) ? CLK_P : SUB_P;
        tol = (code < 3'd4) ? 0.0 : CLK_P;
        wr(2'd2, 8'b0000_0101);
        wr(2'd0, {code, 5'b0});
        wait_out_rise(t0); wait_out_rise(t0); wait_out_rise(t1);
      end
      d = t1 - t0;
      expv = base * real'(1 << sh);
      check((d >= expv - tol - 0.01) && (d <= expv + tol + 0.01), tag,
            $sformatf("vec %0d code %0d period actual %0.1f ns expected %0.1f ns", i, code, d, expv));
    end

    // R10: mode register reads back
    wr(2'd0, 8'hE7);
    rd(2'd0, v); check(v == 8'hE7, "R10", $sformatf("mode readback actual %h expected E7", v));

    // R3: overflow at the fastest interval rate
    wr(2'd0, 8'h07);
    wr(2'd2, 8'h00);
    begin
      int n = 0;
      do begin rd(2'd1, v); n++; end while (v != 8'hFF && n < LIMIT);
      do begin rd(2'd1, v); n++; end while (v == 8'hFF && n < LIMIT);
      if (n >= LIMIT) timed_out = 1'b1;
    end
    check(v == 8'h00, "R3", $sformatf("count after FF actual %h expected 00", v));
    rd(2'd2, v); check(v[0] == 1'b1, "R3", $sformatf("flag after overflow actual %b expected 1", v[0]));
    check(irq == 1'b0, "R4", $sformatf("irq with enable off actual %b expected 0", irq));

    // R4: enable raises irq as a level
    wr(2'd2, 8'b0000_0011);
    check(irq == 1'b1, "R4", $sformatf("irq with flag and enable actual %b expected 1", irq));
    repeat (20) @(negedge clk);
    check(irq == 1'b1, "R4", $sformatf("irq held actual %b expected 1", irq));

    // R5: clear by writing 0, writing 1 has no effect
    wr(2'd2, 8'b0000_0010);
    rd(2'd2, v); check(v[0] == 1'b0, "R5", $sformatf("flag after clear actual %b expected 0", v[0]));
    check(irq == 1'b0, "R4", $sformatf("irq after clear actual %b expected 0", irq));
    wr(2'd2, 8'b0000_0011);
    rd(2'd2, v); check(v[0] == 1'b0, "R5", $sformatf("flag after writing 1 actual %b expected 0", v[0]));
    wr(2'd2, 8'b0000_0010);

    // R6: clear write lands on the overflow edge
    begin
      int n = 0;
      do begin rd(2'd1, v); n++; end while (v != 8'hFF && n < 4 * LIMIT);
      if (n >= 4 * LIMIT) timed_out = 1'b1;
    end
    repeat (6) @(negedge clk);
    wr(2'd2, 8'b0000_0010);
    rd(2'd1, v); check(v == 8'h00, "R6", $sformatf("count on collision actual %h expected 00", v));
    rd(2'd2, v); check(v[0] == 1'b1, "R6", $sformatf("flag on collision actual %b expected 1", v[0]));
    check(irq == 1'b1, "R4", $sformatf("irq after collision actual %b expected 1", irq));

    // R8: time-base clear resets counter and sub prescaler
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h0B);
    wait_cnt_change(t0); wait_cnt_change(t0); wait_cnt_change(t0);
    wr(2'd0, 8'h0F);
    t0 = $realtime;
    rd(2'd1, v); check(v == 8'h00, "R8", $sformatf("count after clear actual %h expected 00", v));
    rd(2'd0, v); check(v == 8'h0F, "R10", $sformatf("mode readback actual %h expected 0F", v));
    begin
      int n = 0;
      do begin rd(2'd1, v); n++; end while (v == 8'h00 && n < LIMIT);
      if (n >= LIMIT) timed_out = 1'b1;
    end
    t1 = $realtime;
    d = t1 - t0;
    check(d >= 8.0 * SUB_P, "R8",
          $sformatf("first step after clear actual %0.1f ns expected >= %0.1f ns", d, 8.0 * SUB_P));

    // R10: counter ignores writes
    wr(2'd1, 8'hAA);
    rd(2'd1, v); check(v != 8'hAA && v < 8'h04, "R10", $sformatf("count after write actual %h expected small, not AA", v));

    done = 1'b1;
    summary();
  end
endmodule